// File: doc/BRIEF.md
# Integer Divide and Modulo Unit

A multi-cycle integer division engine for an execution pipeline. After a one-cycle `start_i` pulse it takes two operands and works out either a quotient or a remainder. Both operands can be signed or unsigned. The operation runs at full register width or on the low halves of the operands (word forms). An extended divide option forms the dividend by placing the first operand in the upper half of a double-width value and filling the lower half with zeros.

Division runs on operand magnitudes with a restoring loop that produces one quotient bit per cycle. Sign correction and the fit checks are applied at the end. Operand pairs whose result would be undefined are caught before the loop starts and finish at once. These cases are a zero divisor, the most-negative value divided by minus one, and extended quotients that cannot fit. In every overflow case the result is forced to zero and an overflow flag is raised; the unit never traps. The unit also produces write strobes for the overflow status and the three-bit condition field, so the surrounding pipeline can apply them. Register writeback and the sticky summary bit are handled outside this block.

Top module: `int_div_unit`

## Requirements
- R1: With `op_i`=0 (divide) and `sgn_i`=0, the result is the unsigned quotient rounded down, at full width when `word_i`=0.
- R2: With `op_i`=0 and `sgn_i`=1, the quotient is truncated toward zero and is negative exactly when the operand signs differ.
- R3: With `op_i`=1 (modulo), the result is the remainder. Its magnitude is less than the divisor's, and in signed mode its sign follows the dividend.
- R4: A zero divisor, signed or unsigned, gives `ov_o`=1 and result 0. `done_o` is high in the first cycle after the accepting edge, and no iterations run.
- R5: In signed mode, a dividend at the most-negative value of the active width together with a divisor of -1 gives `ov_o`=1 and result 0. This holds for both divide and modulo, at both widths.
- R6: An unsigned extended divide (`ext_i`=1) returns floor(a·2^W / b), where W is the active width. It succeeds only when a < b; otherwise `ov_o`=1 and the result is 0.
- R7: A signed extended divide returns the truncated quotient of a·2^W / b. When that quotient does not fit in W signed bits, `ov_o`=1 and the result is 0.
- R8: With `word_i`=1, only operand bits [XLEN/2-1:0] are used. The result sits in the low half and the upper half is zero.
- R9: When `done_o` is high, `ov_we_o` equals divide AND `oe_i`, and `cr_we_o` equals divide AND `rc_i`. A modulo never raises either strobe.
- R10: `cr_o` is {lt,gt,eq} (bit 2 = lt, bit 1 = gt, bit 0 = eq). It reflects the signed value of the W-bit result, so an overflow gives 3'b001.
- R11: After reset the unit is idle and `done_o`, `busy_o` and `result_o` are 0. Counting the cycle after the accepting edge as cycle 1, a non-overflowing-at-entry operation raises `done_o` in cycle XLEN+1. `done_o` is a one-cycle pulse.
- R12: While `busy_o` is high, `start_i` and the operand inputs are ignored.
- R13: `ext_i` has no effect on modulo operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted when idle |
| op_i | input | 1 | 0 = divide, 1 = modulo |
| sgn_i | input | 1 | Signed operands |
| word_i | input | 1 | Use low halves of the operands |
| ext_i | input | 1 | Extended dividend (divide only) |
| oe_i | input | 1 | Request overflow status update |
| rc_i | input | 1 | Request condition field update |
| a_i | input | XLEN | Dividend operand |
| b_i | input | XLEN | Divisor operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Result valid pulse |
| result_o | output | XLEN | Quotient or remainder |
| ov_o | output | 1 | Overflow detected |
| ov_we_o | output | 1 | Write strobe for overflow status |
| cr_o | output | 3 | Condition field {lt,gt,eq} |
| cr_we_o | output | 1 | Write strobe for condition field |

## Verification
The bench builds the unit with XLEN=64, so word forms run at 32 bits and full forms at 64 bits. Both most-negative-by-minus-one cases and both extended fit boundaries can therefore be reached: 2^63 positive must fail, and -2^63 must fit. The 64-iteration latency, the single-cycle early exit and the busy lockout are all measured against this width.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic {OP_DIV = 1'b0, OP_MOD = 1'b1} div_op_e;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_FIN = 2'd2} div_st_e;

  typedef struct packed {
    div_op_e op;
    logic    sgn;
    logic    word;
    logic    ext;
    logic    oe;
    logic    rc;
    logic    q_neg;
    logic    r_neg;
    logic    early_ov;
  } div_ctx_t;
endpackage

// File: rtl/div_prep.sv
module div_prep
  import div_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  div_op_e           op_i,
  input  logic              sgn_i,
  input  logic              word_i,
  input  logic              ext_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  output logic [XLEN-1:0]   hi_o,
  output logic [XLEN-1:0]   lo_o,
  output logic [XLEN-1:0]   den_o,
  output logic              q_neg_o,
  output logic              r_neg_o,
  output logic              early_ov_o
);
  localparam int HW = XLEN / 2;
  localparam logic [XLEN-1:0] FULL_MIN = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] HALF_MIN = {{HW{1'b0}}, 1'b1, {(HW-1){1'b0}}};
  localparam logic [XLEN-1:0] ONE      = {{(XLEN-1){1'b0}}, 1'b1};

  logic [XLEN-1:0] a_x, b_x, mag_a, mag_b;
  logic            neg_a, neg_b, ext_eff, zero_div, min_neg1, fit_pre;

  always_comb begin
    if (word_i) begin
      a_x = {{HW{sgn_i & a_i[HW-1]}}, a_i[HW-1:0]};
      b_x = {{HW{sgn_i & b_i[HW-1]}}, b_i[HW-1:0]};
    end else begin
      a_x = a_i;
      b_x = b_i;
    end
    neg_a    = sgn_i & a_x[XLEN-1];
    neg_b    = sgn_i & b_x[XLEN-1];
    mag_a    = neg_a ? (~a_x + ONE) : a_x;
    mag_b    = neg_b ? (~b_x + ONE) : b_x;
    ext_eff  = ext_i & (op_i == OP_DIV);
    zero_div = (mag_b == '0);
    // most-negative / -1 at the active width
    min_neg1 = neg_a & neg_b & (mag_b == ONE) & (mag_a == (word_i ? HALF_MIN : FULL_MIN));
    // extended quotient magnitude reaches 2^W when |a| >= |b|
    fit_pre  = ext_eff & (mag_a >= mag_b);
    early_ov_o = zero_div | min_neg1 | fit_pre;

    if (ext_eff && !word_i) begin
      hi_o = mag_a;
      lo_o = '0;
    end else if (ext_eff) begin
      hi_o = '0;
      lo_o = mag_a << HW;
    end else begin
      hi_o = '0;
      lo_o = mag_a;
    end
    den_o   = mag_b;
    q_neg_o = neg_a ^ neg_b;
    r_neg_o = neg_a;
  end
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int N = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [N-1:0]  hi_i,
  input  logic [N-1:0]  lo_i,
  input  logic [N-1:0]  den_i,
  output logic [N-1:0]  quo_o,
  output logic [N-1:0]  rem_o
);
  logic [N-1:0] rem_q, dq_q, den_q;
  logic [N:0]   trial, diff;

  always_comb begin
    trial = {rem_q, dq_q[N-1]};
    diff  = trial - {1'b0, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      dq_q  <= '0;
      den_q <= '0;
    end else if (load_i) begin
      rem_q <= hi_i;
      dq_q  <= lo_i;
      den_q <= den_i;
    end else if (step_i) begin
      if (!diff[N]) begin
        rem_q <= diff[N-1:0];
        dq_q  <= {dq_q[N-2:0], 1'b1};
      end else begin
        rem_q <= trial[N-1:0];
        dq_q  <= {dq_q[N-2:0], 1'b0};
      end
    end
  end

  assign quo_o = dq_q;
  assign rem_o = rem_q;

  AST_HI_BELOW_DEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (hi_i < den_i)); // R6
  AST_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (rem_q < den_q)); // R3
endmodule

// File: rtl/div_post.sv
module div_post
  import div_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  div_ctx_t          ctx_i,
  input  logic [XLEN-1:0]   quo_i,
  input  logic [XLEN-1:0]   rem_i,
  output logic [XLEN-1:0]   res_o,
  output logic              ov_o,
  output logic [2:0]        cr_o
);
  localparam int HW = XLEN / 2;
  localparam logic [XLEN-1:0] FULL_MIN = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] HALF_MIN = {{HW{1'b0}}, 1'b1, {(HW-1){1'b0}}};

  logic [XLEN-1:0] mag, val, lim;
  logic            neg, is_div, fit_ov, msb, zero;

  always_comb begin
    is_div = (ctx_i.op == OP_DIV);
    mag    = is_div ? quo_i : rem_i;
    neg    = is_div ? ctx_i.q_neg : ctx_i.r_neg;
    val    = neg ? (~mag + 1'b1) : mag;
    lim    = ctx_i.word ? HALF_MIN : FULL_MIN;
    // negative side admits one more magnitude than positive
    fit_ov = is_div & ctx_i.ext & ctx_i.sgn & (neg ? (mag > lim) : (mag >= lim));
    ov_o   = ctx_i.early_ov | fit_ov;
    if (ov_o)            res_o = '0;
    else if (ctx_i.word) res_o = {{HW{1'b0}}, val[HW-1:0]};
    else                 res_o = val;
    msb  = ctx_i.word ? res_o[HW-1] : res_o[XLEN-1];
    zero = (res_o == '0);
    cr_o = {msb, ~msb & ~zero, zero};
  end
endmodule

// File: rtl/int_div_unit.sv
module int_div_unit
  import div_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_i,
  input  logic              sgn_i,
  input  logic              word_i,
  input  logic              ext_i,
  input  logic              oe_i,
  input  logic              rc_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [XLEN-1:0]   result_o,
  output logic              ov_o,
  output logic              ov_we_o,
  output logic [2:0]        cr_o,
  output logic              cr_we_o
);
  localparam int CW = $clog2(XLEN);
  localparam logic [CW-1:0] LAST = CW'(XLEN - 1);

  div_st_e         state_q;
  logic [CW-1:0]   cnt_q;
  div_ctx_t        ctx_q;
  logic            accept, early_ov, q_neg, r_neg, post_ov;
  logic [XLEN-1:0] hi, lo, den, quo, rem, post_res;
  logic [2:0]      post_cr;

  assign accept = start_i & (state_q == ST_IDLE);

  div_prep #(.XLEN(XLEN)) u_prep (
    .op_i       (div_op_e'(op_i)),
    .sgn_i      (sgn_i),
    .word_i     (word_i),
    .ext_i      (ext_i),
    .a_i        (a_i),
    .b_i        (b_i),
    .hi_o       (hi),
    .lo_o       (lo),
    .den_o      (den),
    .q_neg_o    (q_neg),
    .r_neg_o    (r_neg),
    .early_ov_o (early_ov)
  );

  div_core #(.N(XLEN)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept & ~early_ov),
    .step_i (state_q == ST_RUN),
    .hi_i   (hi),
    .lo_i   (lo),
    .den_i  (den),
    .quo_o  (quo),
    .rem_o  (rem)
  );

  div_post #(.XLEN(XLEN)) u_post (
    .ctx_i (ctx_q),
    .quo_i (quo),
    .rem_i (rem),
    .res_o (post_res),
    .ov_o  (post_ov),
    .cr_o  (post_cr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ctx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          ctx_q   <= '{op: div_op_e'(op_i), sgn: sgn_i, word: word_i, ext: ext_i,
                       oe: oe_i, rc: rc_i, q_neg: q_neg, r_neg: r_neg, early_ov: early_ov};
          cnt_q   <= '0;
          state_q <= early_ov ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_FIN;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    done_o   = (state_q == ST_FIN);
    busy_o   = (state_q != ST_IDLE);
    result_o = done_o ? post_res : '0;
    ov_o     = done_o & post_ov;
    cr_o     = done_o ? post_cr : 3'b000;
    ov_we_o  = done_o & (ctx_q.op == OP_DIV) & ctx_q.oe;
    cr_we_o  = done_o & (ctx_q.op == OP_DIV) & ctx_q.rc;
  end

  AST_EARLY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && early_ov) |=> done_o); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_MOD_NO_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ctx_q.op == OP_MOD) |-> (!ov_we_o && !cr_we_o)); // R9
  AST_OV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ov_o) |-> (result_o == '0 && cr_o == 3'b001)); // R10
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(ctx_q)); // R12
endmodule

// File: tb/tb_int_div_unit.sv
`timescale 1ns/1ps
module tb_int_div_unit;
  localparam int XLEN = 64;

  typedef struct packed {
    logic        op;
    logic        sgn;
    logic        word;
    logic        ext;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] res;
    logic        ov;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0, 64'd100, 64'd7, 64'd14, 1'b0, 8'd1},                                     // R1
    '{1'b0,1'b0,1'b0,1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 8'd1},      // R1
    '{1'b0,1'b1,1'b0,1'b0, 64'hFFFF_FFFF_FFFF_FFF9, 64'd2, 64'hFFFF_FFFF_FFFF_FFFD, 1'b0, 8'd2},      // R2
    '{1'b0,1'b1,1'b0,1'b0, 64'd7, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFD, 1'b0, 8'd2},      // R2
    '{1'b1,1'b1,1'b0,1'b0, 64'hFFFF_FFFF_FFFF_FFF9, 64'd2, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 8'd3},      // R3
    '{1'b1,1'b1,1'b0,1'b0, 64'd7, 64'hFFFF_FFFF_FFFF_FFFE, 64'd1, 1'b0, 8'd3},                        // R3
    '{1'b1,1'b0,1'b0,1'b0, 64'd100, 64'd7, 64'd2, 1'b0, 8'd3},                                       // R3
    '{1'b0,1'b0,1'b0,1'b0, 64'd5, 64'd0, 64'd0, 1'b1, 8'd4},                                         // R4
    '{1'b0,1'b1,1'b0,1'b0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b1, 8'd5},      // R5
    '{1'b1,1'b1,1'b1,1'b0, 64'h1234_5678_8000_0000, 64'h0000_0000_FFFF_FFFF, 64'd0, 1'b1, 8'd5},      // R5
    '{1'b0,1'b0,1'b1,1'b0, 64'hDEAD_BEEF_0000_0064, 64'hFFFF_FFFF_0000_0007, 64'd14, 1'b0, 8'd8},     // R8
    '{1'b0,1'b1,1'b1,1'b0, 64'h0000_0001_FFFF_FFF9, 64'hABCD_0000_0000_0002, 64'h0000_0000_FFFF_FFFD, 1'b0, 8'd8}, // R8
    '{1'b0,1'b0,1'b0,1'b1, 64'd1, 64'd3, 64'h5555_5555_5555_5555, 1'b0, 8'd6},                        // R6
    '{1'b0,1'b0,1'b0,1'b1, 64'd3, 64'd3, 64'd0, 1'b1, 8'd6},                                          // R6
    '{1'b0,1'b1,1'b0,1'b1, 64'd1, 64'd4, 64'h4000_0000_0000_0000, 1'b0, 8'd7},                        // R7
    '{1'b0,1'b1,1'b0,1'b1, 64'd1, 64'd2, 64'd0, 1'b1, 8'd7},                                          // R7
    '{1'b0,1'b1,1'b0,1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'h8000_0000_0000_0000, 1'b0, 8'd7},      // R7
    '{1'b0,1'b0,1'b1,1'b1, 64'h7777_0000_0000_0001, 64'd3, 64'h0000_0000_5555_5555, 1'b0, 8'd6},      // R6
    '{1'b0,1'b1,1'b1,1'b1, 64'h0000_0000_FFFF_FFFF, 64'd4, 64'h0000_0000_C000_0000, 1'b0, 8'd7},      // R7
    '{1'b1,1'b1,1'b0,1'b1, 64'hFFFF_FFFF_FFFF_FFF9, 64'd2, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 8'd13},     // R13
    '{1'b1,1'b0,1'b0,1'b0, 64'd9, 64'd0, 64'd0, 1'b1, 8'd4}                                           // R4
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op = 1'b0, sgn = 1'b0, word = 1'b0, ext = 1'b0, oe = 1'b0, rc = 1'b0;
  logic [XLEN-1:0] a = '0, b = '0;
  logic busy, done, ov, ov_we, cr_we;
  logic [XLEN-1:0] result;
  logic [2:0] cr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  int_div_unit #(.XLEN(XLEN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .sgn_i(sgn),
    .word_i(word), .ext_i(ext), .oe_i(oe), .rc_i(rc), .a_i(a), .b_i(b),
    .busy_o(busy), .done_o(done), .result_o(result), .ov_o(ov),
    .ov_we_o(ov_we), .cr_o(cr), .cr_we_o(cr_we)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_cr(input logic w, input logic [63:0] r);
    logic m, z;
    m = w ? r[31] : r[63];
    z = (r == 64'd0);
    return {m, ~m & ~z, z};
  endfunction

  // returns the cycle index (1 = first cycle after accepting edge) in which done is seen
  task automatic run_op(input logic o, s, w, e, input logic [63:0] av, bv, output int cyc);
    @(negedge clk);
    op = o; sgn = s; word = w; ext = e; a = av; b = bv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!done && !busy && result == '0, "R11 reset", {62'd0, done, busy}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy, "R11 idle", {62'd0, done, busy}, 64'd0);

    oe = 1'b1; rc = 1'b1;
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i].op, VEC[i].sgn, VEC[i].word, VEC[i].ext, VEC[i].a, VEC[i].b, cyc);
      chk(done && result == VEC[i].res && ov == VEC[i].ov,
          $sformatf("R%0d vec%0d result", VEC[i].req, i), result, VEC[i].res);
      chk(cr == exp_cr(VEC[i].word, VEC[i].res),
          $sformatf("R10 vec%0d cr", i), {61'd0, cr}, {61'd0, exp_cr(VEC[i].word, VEC[i].res)});
      chk(ov_we == !VEC[i].op && cr_we == !VEC[i].op,
          $sformatf("R9 vec%0d strobes", i), {62'd0, ov_we, cr_we}, {62'd0, !VEC[i].op, !VEC[i].op});
      @(negedge clk);
      chk(!done, "R11 done pulse", {63'd0, done}, 64'd0);
    end

    // R4 early exit latency
    run_op(1'b0, 1'b1, 1'b0, 1'b0, 64'd77, 64'd0, cyc);
    chk(cyc == 1, "R4 latency", 64'(cyc), 64'd1);
    // R11 full latency
    run_op(1'b0, 1'b0, 1'b0, 1'b0, 64'd1000, 64'd3, cyc);
    chk(cyc == XLEN + 1 && result == 64'd333, "R11 latency", 64'(cyc), 64'(XLEN + 1));

    // R9 strobes off when not requested
    oe = 1'b0; rc = 1'b0;
    run_op(1'b0, 1'b0, 1'b0, 1'b0, 64'd8, 64'd0, cyc);
    chk(!ov_we && !cr_we && ov, "R9 no request", {62'd0, ov_we, cr_we}, 64'd0);

    // R12 start ignored while busy
    @(negedge clk);
    op = 1'b0; sgn = 1'b0; word = 1'b0; ext = 1'b0; a = 64'd100; b = 64'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy, "R12 busy", {63'd0, busy}, 64'd1);
    op = 1'b1; a = 64'd1000; b = 64'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    chk(done && result == 64'd14 && !ov, "R12 ignored start", result, 64'd14);
    @(negedge clk);
    chk(!busy && !done, "R12 idle after", {62'd0, busy, done}, 64'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule